// File: doc/BRIEF.md
# Tiled Image Rotation Engine

This engine turns an image by a quarter turn in either direction, or mirrors it across one axis. It works on one square tile at a time. A start pulse latches a transform select and the image size, counted in whole tiles. The engine then asks for source tiles in raster order, with the column index running fastest. For each tile it announces the tile's coordinates on a read-request strobe and takes in exactly one tile of pixels, in raster order, from a valid/ready input stream. It stores them in an on-chip tile buffer. It then announces where the transformed tile belongs in the output image, using a write-request strobe with destination coordinates. Finally it plays the buffer back through a valid/ready output stream in the transformed order.

A four-state controller sequences the work. IDLE is the reset state. It moves to RECEIVE on start (idle→receive), to SEND once a full tile has been stored (receive→send), and back to RECEIVE for the next tile (send→receive). After the last tile has been written back it moves to END (send→end), and from there it always returns to IDLE (end→idle). If either dimension is zero, start goes directly to END (idle→end). A done strobe marks the END cycle and an interrupt pulse follows it, so a processor can collect the finished image. The tile side, pixel width and tile-count width are parameters.

Top module: `tile_rotator`

## Requirements
- R1: After reset the engine is idle: in_ready, out_valid, rd_req, wr_req, done and irq are all 0.
- R2: A start pulse while idle with nonzero width and height causes, in the next cycle, an rd_req pulse for tile (x=0, y=0) with in_ready high. Tiles are requested in raster order (x fastest), one rd_req per tile, W*H in total.
- R3: in_ready is high only while receiving. Exactly TILE*TILE pixels are accepted per tile, in raster order. The cycle after the last one, wr_req pulses with out_valid high and the destination tile coordinates.
- R4: mode 2'b00 turns the image clockwise. Output pixel (r,c) of a tile is source pixel (TILE-1-c, r). Source tile (x,y) goes to destination (x'=H-1-y, y'=x).
- R5: mode 2'b01 turns the image counter-clockwise. Output pixel (r,c) is source (c, TILE-1-r). Tile (x,y) goes to (x'=y, y'=W-1-x).
- R6: mode 2'b10 mirrors left/right. Output pixel (r,c) is source (r, TILE-1-c). Tile (x,y) goes to (x'=W-1-x, y'=y).
- R7: mode 2'b11 mirrors top/bottom. Output pixel (r,c) is source (TILE-1-r, c). Tile (x,y) goes to (x'=x, y'=H-1-y).
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold. Gaps in in_valid lose no pixel.
- R9: When the tiles-written count reaches W*H, done is high for exactly one cycle and the engine returns to idle. irq pulses for one cycle, in the cycle after done.
- R10: A start with width or height equal to 0 gives done in the next cycle, with no rd_req, followed by irq.
- R11: start and mode are ignored outside IDLE. A run keeps the transform latched at its start and emits no extra tiles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (sampled in IDLE only) |
| mode | input | 2 | Transform select, latched at start |
| width_tiles | input | DIM_W | Image width in tiles |
| height_tiles | input | DIM_W | Image height in tiles |
| rd_req | output | 1 | One-cycle strobe: source tile wanted |
| rd_tile_x | output | DIM_W | Source tile column |
| rd_tile_y | output | DIM_W | Source tile row |
| in_valid | input | 1 | Input pixel valid |
| in_data | input | PIX_W | Input pixel |
| in_ready | output | 1 | Engine accepts input pixel |
| wr_req | output | 1 | One-cycle strobe: tile about to be written |
| wr_tile_x | output | DIM_W | Destination tile column |
| wr_tile_y | output | DIM_W | Destination tile row |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | PIX_W | Output pixel |
| out_ready | input | 1 | Consumer accepts output pixel |
| done | output | 1 | One-cycle strobe in END |
| irq | output | 1 | One-cycle interrupt after done |

## Verification
The bench builds the engine with TILE=4, PIX_W=8 and DIM_W=4. A tile then holds 16 pixels, so every pixel of every tile can be compared against the index formula for each of the four transforms. Every input pixel carries its global arrival index as its value, so a misplaced pixel shows up directly. The image is 3 tiles wide and 2 tiles high. With a non-square tile grid, a swapped width and height, or a missing "minus one" in the destination tile formula, gives wrong coordinates. Stalls on both streams, a stray start during a run, and a zero dimension cover the hold, ignore and empty-image paths.

// File: rtl/rot_pkg.sv
package rot_pkg;

    typedef enum logic [1:0] {
        ROT_RIGHT = 2'b00,
        ROT_LEFT  = 2'b01,
        FLIP_H    = 2'b10,
        FLIP_V    = 2'b11
    } rot_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_SEND,
        ST_END
    } rot_state_e;

endpackage

// File: rtl/rot_tile_mem.sv
module rot_tile_mem #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 2304,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [PIX_W-1:0] rdata
);

    logic [PIX_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // read is combinational so the output word follows the remapped index
    assign rdata = store[raddr];

endmodule

// File: rtl/rot_pix_map.sv
module rot_pix_map
    import rot_pkg::*;
#(
    parameter int TILE = 48,
    parameter int CW   = $clog2(TILE),
    parameter int AW   = $clog2(TILE * TILE)
) (
    input  rot_mode_e         mode,
    input  logic [CW-1:0]     out_r,
    input  logic [CW-1:0]     out_c,
    output logic [AW-1:0]     src_idx
);

    localparam logic [CW-1:0] LAST = CW'(TILE - 1);

    logic [CW-1:0] src_r;
    logic [CW-1:0] src_c;

    always_comb begin
        unique case (mode)
            ROT_RIGHT: begin src_r = LAST - out_c; src_c = out_r;         end
            ROT_LEFT:  begin src_r = out_c;        src_c = LAST - out_r;  end
            FLIP_H:    begin src_r = out_r;        src_c = LAST - out_c;  end
            FLIP_V:    begin src_r = LAST - out_r; src_c = out_c;         end
        endcase
    end

    assign src_idx = AW'(src_r) * AW'(TILE) + AW'(src_c);

endmodule

// File: rtl/rot_tile_map.sv
module rot_tile_map
    import rot_pkg::*;
#(
    parameter int DW = 8
) (
    input  rot_mode_e     mode,
    input  logic [DW-1:0] tx,
    input  logic [DW-1:0] ty,
    input  logic [DW-1:0] w,
    input  logic [DW-1:0] h,
    output logic [DW-1:0] dst_x,
    output logic [DW-1:0] dst_y
);

    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        unique case (mode)
            ROT_RIGHT: begin dst_x = h - ONE - ty; dst_y = tx;            end
            ROT_LEFT:  begin dst_x = ty;           dst_y = w - ONE - tx;  end
            FLIP_H:    begin dst_x = w - ONE - tx; dst_y = ty;            end
            FLIP_V:    begin dst_x = tx;           dst_y = h - ONE - ty;  end
        endcase
    end

endmodule

// File: rtl/tile_rotator.sv
module tile_rotator
    import rot_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int TILE  = 48,
    parameter int DIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [DIM_W-1:0] width_tiles,
    input  logic [DIM_W-1:0] height_tiles,
    output logic             rd_req,
    output logic [DIM_W-1:0] rd_tile_x,
    output logic [DIM_W-1:0] rd_tile_y,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    output logic             in_ready,
    output logic             wr_req,
    output logic [DIM_W-1:0] wr_tile_x,
    output logic [DIM_W-1:0] wr_tile_y,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    input  logic             out_ready,
    output logic             done,
    output logic             irq
);

    localparam int TILE_PIX = TILE * TILE;
    localparam int AW       = $clog2(TILE_PIX);
    localparam int CW       = $clog2(TILE);
    localparam int CNT_W    = 2 * DIM_W;
    localparam logic [AW-1:0] IDX_LAST = AW'(TILE_PIX - 1);
    localparam logic [CW-1:0] CRD_LAST = CW'(TILE - 1);

    rot_state_e state, state_nx;

    rot_mode_e        mode_q;
    logic [DIM_W-1:0] w_q, h_q;
    logic [CNT_W-1:0] total_q;
    logic [DIM_W-1:0] tx_q, ty_q;
    logic [AW-1:0]    in_idx;
    logic [CW-1:0]    out_r, out_c;
    logic [CNT_W-1:0] rd_cnt, wr_cnt;
    logic             blk_rcvd, blk_sent;
    logic             rd_req_q, wr_req_q, irq_q;
    logic [DIM_W-1:0] rd_x_q, rd_y_q, wr_x_q, wr_y_q;

    logic             in_fire, out_fire, in_last, out_last, final_tile;
    logic             dims_zero;
    logic [AW-1:0]    rd_idx;
    logic [DIM_W-1:0] dst_x, dst_y;
    logic [DIM_W-1:0] nx_tx, nx_ty;

    assign in_ready   = (state == ST_RECV);
    assign out_valid  = (state == ST_SEND);
    assign in_fire    = in_valid && in_ready;
    assign out_fire   = out_valid && out_ready;
    assign in_last    = in_fire && (in_idx == IDX_LAST);
    assign out_last   = out_fire && (out_r == CRD_LAST) && (out_c == CRD_LAST);
    assign final_tile = (wr_cnt + CNT_W'(1)) == total_q;
    assign dims_zero  = (width_tiles == '0) || (height_tiles == '0);

    assign nx_tx = (tx_q == w_q - DIM_W'(1)) ? '0 : tx_q + DIM_W'(1);
    assign nx_ty = (tx_q == w_q - DIM_W'(1)) ? ty_q + DIM_W'(1) : ty_q;

    rot_tile_mem #(.PIX_W(PIX_W), .DEPTH(TILE_PIX), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (in_fire),
        .waddr (in_idx),
        .wdata (in_data),
        .raddr (rd_idx),
        .rdata (out_data)
    );

    rot_pix_map #(.TILE(TILE), .CW(CW), .AW(AW)) u_pix (
        .mode    (mode_q),
        .out_r   (out_r),
        .out_c   (out_c),
        .src_idx (rd_idx)
    );

    rot_tile_map #(.DW(DIM_W)) u_tile (
        .mode  (mode_q),
        .tx    (tx_q),
        .ty    (ty_q),
        .w     (w_q),
        .h     (h_q),
        .dst_x (dst_x),
        .dst_y (dst_y)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = dims_zero ? ST_END : ST_RECV;
            ST_RECV: if (in_last) state_nx = ST_SEND;
            ST_SEND: if (out_last) state_nx = final_tile ? ST_END : ST_RECV;
            ST_END:  state_nx = ST_IDLE;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= ROT_RIGHT;
            w_q      <= '0;
            h_q      <= '0;
            total_q  <= '0;
            tx_q     <= '0;
            ty_q     <= '0;
            in_idx   <= '0;
            out_r    <= '0;
            out_c    <= '0;
            rd_cnt   <= '0;
            wr_cnt   <= '0;
            blk_rcvd <= 1'b0;
            blk_sent <= 1'b0;
            rd_req_q <= 1'b0;
            wr_req_q <= 1'b0;
            rd_x_q   <= '0;
            rd_y_q   <= '0;
            wr_x_q   <= '0;
            wr_y_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            rd_req_q <= 1'b0;
            wr_req_q <= 1'b0;
            irq_q    <= (state == ST_END);
            unique case (state)
                ST_IDLE: begin
                    rd_cnt   <= '0;
                    wr_cnt   <= '0;
                    blk_rcvd <= 1'b0;
                    blk_sent <= 1'b0;
                    in_idx   <= '0;
                    out_r    <= '0;
                    out_c    <= '0;
                    if (start) begin
                        mode_q  <= rot_mode_e'(mode);
                        w_q     <= width_tiles;
                        h_q     <= height_tiles;
                        total_q <= CNT_W'(width_tiles) * CNT_W'(height_tiles);
                        tx_q    <= '0;
                        ty_q    <= '0;
                        if (!dims_zero) begin
                            rd_req_q <= 1'b1;
                            rd_x_q   <= '0;
                            rd_y_q   <= '0;
                            rd_cnt   <= CNT_W'(1);
                        end
                    end
                end
                ST_RECV: begin
                    if (in_fire) begin
                        in_idx <= in_last ? '0 : in_idx + AW'(1);
                    end
                    if (in_last) begin
                        blk_rcvd <= 1'b1;
                        blk_sent <= 1'b0;
                        wr_req_q <= 1'b1;
                        wr_x_q   <= dst_x;
                        wr_y_q   <= dst_y;
                        out_r    <= '0;
                        out_c    <= '0;
                    end
                end
                ST_SEND: begin
                    if (out_fire) begin
                        if (out_c == CRD_LAST) begin
                            out_c <= '0;
                            out_r <= out_r + CW'(1);
                        end else begin
                            out_c <= out_c + CW'(1);
                        end
                    end
                    if (out_last) begin
                        blk_sent <= 1'b1;
                        blk_rcvd <= 1'b0;
                        wr_cnt   <= wr_cnt + CNT_W'(1);
                        if (!final_tile) begin
                            tx_q     <= nx_tx;
                            ty_q     <= nx_ty;
                            rd_req_q <= 1'b1;
                            rd_x_q   <= nx_tx;
                            rd_y_q   <= nx_ty;
                            rd_cnt   <= rd_cnt + CNT_W'(1);
                        end
                    end
                end
                ST_END: begin
                    blk_rcvd <= 1'b0;
                end
            endcase
        end
    end

    assign rd_req    = rd_req_q;
    assign rd_tile_x = rd_x_q;
    assign rd_tile_y = rd_y_q;
    assign wr_req    = wr_req_q;
    assign wr_tile_x = wr_x_q;
    assign wr_tile_y = wr_y_q;
    assign done      = (state == ST_END);
    assign irq       = irq_q;

    // R2
    rd_req_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> in_ready);

    // R2
    rd_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (rd_cnt <= total_q));

    // R3
    wr_req_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (out_valid && blk_rcvd));

    // R3
    in_idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_idx <= IDX_LAST);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && irq));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9
    wr_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (wr_cnt <= total_q));

    // R10
    zero_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && dims_zero) |=> (done && !rd_req));

endmodule

// File: tb/tile_rotator_tb_top.sv
`timescale 1ns/1ps
module tile_rotator_tb_top;

    localparam int T  = 4;
    localparam int TP = T * T;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [DW-1:0] w_i = '0, h_i = '0;
    logic          rd_req, wr_req, in_ready, out_valid, done, irq;
    logic [DW-1:0] rd_tile_x, rd_tile_y, wr_tile_x, wr_tile_y;
    logic          in_valid_i = 1'b0;
    logic [7:0]    in_data_i = '0;
    logic [7:0]    out_data;
    logic          out_ready_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] obuf [0:255];

    always #10 clk = ~clk;

    tile_rotator #(.PIX_W(8), .TILE(T), .DIM_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start_i), .mode(mode_i),
        .width_tiles(w_i), .height_tiles(h_i),
        .rd_req(rd_req), .rd_tile_x(rd_tile_x), .rd_tile_y(rd_tile_y),
        .in_valid(in_valid_i), .in_data(in_data_i), .in_ready(in_ready),
        .wr_req(wr_req), .wr_tile_x(wr_tile_x), .wr_tile_y(wr_tile_y),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready_i),
        .done(done), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int src_of(input int m, input int r, input int c);
        case (m)
            0: return (T - 1 - c) * T + r;
            1: return c * T + (T - 1 - r);
            2: return r * T + (T - 1 - c);
            default: return (T - 1 - r) * T + c;
        endcase
    endfunction

    task automatic dest_of(input int m, input int tx, input int ty, input int w, input int h,
                           output int dx, output int dy);
        case (m)
            0: begin dx = h - 1 - ty; dy = tx;         end
            1: begin dx = ty;         dy = w - 1 - tx; end
            2: begin dx = w - 1 - tx; dy = ty;         end
            default: begin dx = tx;   dy = h - 1 - ty; end
        endcase
    endtask

    // R1
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "in_ready", int'(in_ready), 0);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "rd_req", int'(rd_req), 0);
        chk("R1", "wr_req", int'(wr_req), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_image(input int m, input int w, input int h, input bit stall,
                             input bit gaps, input bit poke, input string req);
        int total, in_pix, out_pix, rd_seen, wr_seen, cyc, dx, dy, hv;
        bit fin, held;
        total = w * h;
        in_pix = 0; out_pix = 0; rd_seen = 0; wr_seen = 0; cyc = 0;
        fin = 0; held = 0; hv = 0;
        mode_i = 2'(m); w_i = DW'(w); h_i = DW'(h); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", "rd_req after start", int'(rd_req), 1);
        chk("R2", "in_ready after start", int'(in_ready), 1);
        while (!fin && cyc < 4000) begin
            if (held) begin
                chk("R8", "out_valid held", int'(out_valid), 1);
                chk("R8", "out_data held", int'(out_data), hv);
                held = 0;
            end
            if (rd_req) begin
                chk("R2", "rd tile x", int'(rd_tile_x), rd_seen % w);
                chk("R2", "rd tile y", int'(rd_tile_y), rd_seen / w);
                rd_seen++;
            end
            if (wr_req) begin
                dest_of(m, wr_seen % w, wr_seen / w, w, h, dx, dy);
                chk(req, "wr tile x", int'(wr_tile_x), dx);
                chk(req, "wr tile y", int'(wr_tile_y), dy);
                chk("R3", "pixels in at wr_req", in_pix, (wr_seen + 1) * TP);
                wr_seen++;
            end
            if (done) begin
                fin = 1;
            end else begin
                start_i = poke && (cyc == 5);
                if (poke && cyc == 5) mode_i = 2'(m ^ 1);
                in_valid_i = gaps ? (cyc % 3 != 1) : 1'b1;
                in_data_i = 8'(in_pix);
                out_ready_i = stall ? (cyc % 2 == 1) : 1'b1;
                #1;
                if (in_valid_i && in_ready) in_pix++;
                if (out_valid && out_ready_i) begin
                    obuf[out_pix] = out_data;
                    out_pix++;
                end
                if (out_valid && !out_ready_i) begin
                    held = 1;
                    hv = int'(out_data);
                end
                @(negedge clk);
                cyc++;
            end
        end
        in_valid_i = 1'b0;
        start_i = 1'b0;
        chk("R9", "done reached", int'(fin), 1);
        chk("R9", "pixels out at done", out_pix, total * TP);
        chk("R3", "pixels in at done", in_pix, total * TP);
        chk("R2", "read requests", rd_seen, total);
        chk("R11", "write requests", wr_seen, total);
        @(negedge clk);
        chk("R9", "done one cycle", int'(done), 0);
        chk("R9", "irq after done", int'(irq), 1);
        @(negedge clk);
        chk("R9", "irq one cycle", int'(irq), 0);
        chk("R9", "idle after end", int'(in_ready), 0);
        for (int j = 0; j < total; j++) begin
            for (int p = 0; p < TP; p++) begin
                chk(req, "pixel", int'(obuf[j * TP + p]), j * TP + src_of(m, p / T, p % T));
            end
        end
    endtask

    // R10
    task automatic test_zero();
        w_i = '0; h_i = DW'(2); mode_i = 2'b00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10", "done on zero width", int'(done), 1);
        chk("R10", "no rd_req", int'(rd_req), 0);
        chk("R10", "no in_ready", int'(in_ready), 0);
        @(negedge clk);
        chk("R10", "irq after zero job", int'(irq), 1);
        chk("R10", "done cleared", int'(done), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        run_image(0, 3, 2, 1'b0, 1'b0, 1'b0, "R4");
        run_image(1, 3, 2, 1'b0, 1'b1, 1'b0, "R5");
        run_image(2, 3, 2, 1'b1, 1'b0, 1'b0, "R6");
        run_image(3, 3, 2, 1'b1, 1'b1, 1'b1, "R7");
        test_zero();
        run_image(0, 1, 1, 1'b0, 1'b0, 1'b0, "R4");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule